// File: doc/BRIEF.md
# Prescaled Sequencing Delay Timers

This block is a bank of delay timers that a power-up sequencing state machine uses to space out its steps. A base time strobe of one microsecond is formed either from the local clock, by dividing it down, or from an external reference clock input. When the external source is used, every delay scales with that clock's frequency. A shared prescaler divides the base strobe by a power of two. Its output is a one-cycle tick that all timers count.

Each timer has its own 8-bit terminal value and its own run line. While run is low the timer stays cleared. Once run is raised, the timer counts ticks. After its terminal value plus one ticks it raises its expired flag, and the flag stays high until run drops. With an 8-bit terminal value and prescaler settings from 2^5 to 2^11 microseconds, delays from 32 µs to about 524 ms can be set. Every counter runs in the single clock domain of `clk`.

Top module: `seq_delay_timers`

## Requirements
- R1: After reset every expired flag is 0.
- R2: While a timer's run input is low, its expired flag reads 0 from the cycle after run is sampled low. This holds whatever ticks occur.
- R3: With run held high, a timer's expired flag rises after it has counted term+1 ticks. Measured from the clock edge that first samples run high, the flag is visible after between term·P+1 and (term+1)·P edges, where P is the tick period in clock cycles.
- R4: A terminal value of 0 makes the timer expire on the first tick after run is raised, within P edges.
- R5: Once set, expired stays 1 for as long as run stays high. The count does not wrap around.
- R6: The tick period is the base strobe period times 2^sel, where sel is the 4-bit `pre_sel` input (0 to 15).
- R7: With `ext_sel` = 0 (internal source), the base strobe comes once every BASE_DIV clock cycles.
- R8: With `ext_sel` = 1 (external source), the base strobe comes once per rising edge of `ext_clk`, after a two-stage synchronizer. The base period then equals the `ext_clk` period.
- R9: Timers are independent. Timers started together with different terminal values each expire within their own window.
- R10: Dropping run for one cycle and raising it again restarts the full delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | Base source: 0 = divided local clock, 1 = external clock |
| ext_clk | input | 1 | External reference clock (asynchronous, slower than clk) |
| pre_sel | input | 4 | Prescaler exponent: tick = base period × 2^pre_sel |
| term | input | 32 | Terminal values, 8 bits per timer, timer i at bits [8i+7:8i] |
| run | input | 4 | Per-timer run (high) / hold-cleared (low) |
| expired | output | 4 | Per-timer expired flags |

## Verification
A table of runs varies the timer index, the base source, the prescaler exponent and the terminal value. Each run's measured delay must land inside a window one tick period wide. A wrong terminal comparison shifts the delay by a whole period. An ignored source select or exponent changes the period itself. Both fall outside the window. Directed cases cover terminal value 0 and the maximum of 255, two timers started on the same edge with different terminal values, and a restart after a one-cycle drop of run. Each directed case pairs a long idle with ticks running against expired staying low, and sticky expiry against clearing.

// File: rtl/seq_tmr_pkg.sv
package seq_tmr_pkg;
    // base strobe source encoding for ext_sel
    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_EXT   = 1'b1
    } src_e;

    localparam int unsigned DEF_NUM_TMR  = 4;
    localparam int unsigned DEF_CNT_W    = 8;
    localparam int unsigned DEF_SEL_W    = 4;
    localparam int unsigned DEF_BASE_DIV = 4;
endpackage

// File: rtl/base_strobe.sv
module base_strobe
    import seq_tmr_pkg::*;
#(
    parameter int unsigned BASE_DIV = DEF_BASE_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_clk,
    output logic stb
);
    localparam int unsigned DIV_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BASE_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [1:0]       sync;
        logic             prev;
        logic             stb;
    } bs_state_t;

    bs_state_t st_d, st_q;
    src_e      src;

    assign src = src_e'(ext_sel);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], ext_clk};
        st_d.prev = st_q.sync[1];
        st_d.div  = (st_q.div == DIV_LAST) ? '0 : st_q.div + 1'b1;
        if (src == SRC_EXT) begin
            st_d.stb = st_q.sync[1] & ~st_q.prev;
        end else begin
            st_d.stb = (st_q.div == DIV_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb = st_q.stb;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import seq_tmr_pkg::*;
#(
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned PRE_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } ps_state_t;

    ps_state_t        st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << sel);
        st_d = st_q;
        if (stb) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick = stb && ((st_q.cnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/delay_timer.sv
module delay_timer
    import seq_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] term,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (tick && !st_q.done) begin
            if (st_q.cnt == term) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.done;
endmodule

// File: rtl/seq_delay_timers.sv
module seq_delay_timers
    import seq_tmr_pkg::*;
#(
    parameter int unsigned NUM_TMR  = DEF_NUM_TMR,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned SEL_W    = DEF_SEL_W,
    parameter int unsigned BASE_DIV = DEF_BASE_DIV
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_sel,
    input  logic                     ext_clk,
    input  logic [SEL_W-1:0]         pre_sel,
    input  logic [NUM_TMR*CNT_W-1:0] term,
    input  logic [NUM_TMR-1:0]       run,
    output logic [NUM_TMR-1:0]       expired
);
    logic base_stb;
    logic tick;

    base_strobe #(.BASE_DIV(BASE_DIV)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_sel),
        .ext_clk (ext_clk),
        .stb     (base_stb)
    );

    tick_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (base_stb),
        .sel   (pre_sel),
        .tick  (tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        delay_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .run     (run[i]),
            .term    (term[i*CNT_W +: CNT_W]),
            .expired (expired[i])
        );
    end
endmodule

// File: rtl/seq_delay_timers_chk.sv
module seq_delay_timers_chk #(
    parameter int unsigned NUM_TMR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_TMR-1:0] run,
    input logic [NUM_TMR-1:0] expired,
    input logic               tick,
    input logic               base_stb
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |=> !expired[i]); // R2
        AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && expired[i]) |=> expired[i]); // R5
        AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(expired[i]) |-> ($past(tick) && $past(run[i]))); // R3
    end

    AST_TICK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> base_stb); // R6
endmodule

bind seq_delay_timers seq_delay_timers_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .expired  (expired),
    .tick     (tick),
    .base_stb (base_stb)
);

// File: tb/test_seq_delay_timers.sv
module test_seq_delay_timers;
    localparam int NT = 4;
    localparam int CW = 8;
    localparam int BDIV = 4;
    localparam int EXT_HALF = 3;
    localparam int EXT_BASE = 2 * EXT_HALF;

    // vector: {idx[1:0], ext, sel[3:0], term[7:0]}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'd0, 8'd0},
        {2'd1, 1'b0, 4'd0, 8'd5},
        {2'd2, 1'b0, 4'd2, 8'd3},
        {2'd3, 1'b0, 4'd3, 8'd255},
        {2'd0, 1'b1, 4'd0, 8'd4},
        {2'd1, 1'b1, 4'd1, 8'd0},
        {2'd2, 1'b0, 4'd5, 8'd2},
        {2'd3, 1'b1, 4'd2, 8'd10}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_sel = 1'b0;
    logic             ext_clk = 1'b0;
    logic [3:0]       pre_sel = '0;
    logic [NT*CW-1:0] term = '0;
    logic [NT-1:0]    run = '0;
    logic [NT-1:0]    expired;

    int errors = 0;
    int checks = 0;

    seq_delay_timers i_seq_delay_timers (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_sel),
        .ext_clk (ext_clk),
        .pre_sel (pre_sel),
        .term    (term),
        .run     (run),
        .expired (expired)
    );

    always #5 clk = ~clk;

    // external reference: toggles every EXT_HALF clk cycles
    initial begin
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period(input bit ext, input int sel);
        return (ext ? EXT_BASE : BDIV) << sel;
    endfunction

    // raise run on timer idx, count edges until expired is seen; returns count
    task automatic measure(input int idx, input int limit, output int k);
        k = 0;
        @(negedge clk);
        run[idx] = 1'b1;
        do begin
            @(posedge clk);
            k++;
            #1;
        end while (!expired[idx] && k < limit);
    endtask

    task automatic configure(input bit ext, input int sel);
        @(negedge clk);
        ext_sel = ext;
        pre_sel = 4'(sel);
        repeat (2 * EXT_BASE + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k, k2, p;
        repeat (3) @(negedge clk);
        chk(expired == '0, "R1 reset", int'(expired), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(expired == '0, "R1 after release", int'(expired), 0);

        // table walk: R3 window, R4 term 0, R6 prescale, R7/R8 source, R5, R2
        for (int v = 0; v < NV; v++) begin
            int idx, sel, tv;
            bit ext;
            idx = int'(VEC[v][14:13]);
            ext = VEC[v][12];
            sel = int'(VEC[v][11:8]);
            tv  = int'(VEC[v][7:0]);
            p   = period(ext, sel);
            configure(ext, sel);
            term[idx*CW +: CW] = 8'(tv);
            measure(idx, (tv + 2) * p + 8, k);
            chk(k >= tv * p + 1 && k <= (tv + 1) * p,
                (tv == 0) ? "R4/R6/R7/R8 first-tick window" : "R3/R6/R7/R8 delay window",
                k, (tv + 1) * p);
            repeat (3 * p) @(negedge clk);
            chk(expired[idx] == 1'b1, "R5 sticky", int'(expired[idx]), 1);
            run[idx] = 1'b0;
            @(posedge clk);
            #1;
            chk(expired[idx] == 1'b0, "R2 clear on run low", int'(expired[idx]), 0);
        end

        // R2: long idle with ticks running, nothing expires
        configure(1'b0, 0);
        term = '0;
        repeat (200) @(negedge clk);
        chk(expired == '0, "R2 idle with ticks", int'(expired), 0);

        // R9: two timers started on the same edge
        configure(1'b0, 1);
        p = period(1'b0, 1);
        term[0*CW +: CW] = 8'd2;
        term[1*CW +: CW] = 8'd6;
        @(negedge clk);
        run[1:0] = 2'b11;
        k = 0;
        k2 = 0;
        for (int c = 1; c <= 10 * p && (k == 0 || k2 == 0); c++) begin
            @(posedge clk);
            #1;
            if (k == 0 && expired[0]) k = c;
            if (k2 == 0 && expired[1]) k2 = c;
        end
        chk(k >= 2 * p + 1 && k <= 3 * p, "R9 timer0 window", k, 3 * p);
        chk(k2 >= 6 * p + 1 && k2 <= 7 * p, "R9 timer1 window", k2, 7 * p);
        chk(expired[3:2] == 2'b00, "R9 idle timers unaffected", int'(expired[3:2]), 0);
        @(negedge clk);
        run = '0;

        // R10: restart after a one-cycle drop
        configure(1'b0, 0);
        p = period(1'b0, 0);
        term[2*CW +: CW] = 8'd10;
        @(negedge clk);
        run[2] = 1'b1;
        repeat (7 * p) @(negedge clk);
        chk(expired[2] == 1'b0, "R10 not yet expired", int'(expired[2]), 0);
        run[2] = 1'b0;
        @(negedge clk);
        run[2] = 1'b0;
        measure(2, 14 * p, k);
        chk(k >= 10 * p + 1 && k <= 11 * p, "R10 full delay after restart", k, 11 * p);
        @(negedge clk);
        run = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule